// File: doc/BRIEF.md
# Indirect Indexed Address Sequencer

This block sequences the pointer-plus-index addressing mode of an 8-bit processor. After a start strobe it makes exactly one memory read per cycle. The reads, in order, are:

1. The opcode, at the program counter.
2. A zero-page byte that names where a 16-bit pointer is stored.
3. The pointer's low byte.
4. The pointer's high byte.
5. The operand, at the pointer plus the Y register.

While the first two reads are on the bus, the block asks the surrounding core to advance the program counter.

The index is added to the pointer's low byte only. When that addition carries into the high byte, the block spends one extra cycle on a throwaway read. That read uses the high byte as it was fetched and the sum's low byte. The high byte is then incremented and the real read follows. With no carry the throwaway cycle is skipped. The operand byte is then held on an output together with a one-cycle completion pulse.

The block sits between an instruction decoder, which raises the start strobe, and a memory port that returns read data combinationally in the same cycle as the address.

Top module: `ind_idx_seq`

## Requirements
- R1: After reset and while idle, `rd_o`, `pc_inc_o` and `done_o` are 0.
- R2: The cycle after `start_i` is sampled high while idle, the block reads at `pc_i` with `rd_o`=1 and `pc_inc_o`=1 (opcode fetch).
- R3: The next cycle reads at `pc_i` (the already advanced value) with `pc_inc_o`=1 (zero-page operand fetch); the byte read there is the pointer location Z.
- R4: The next cycle reads the pointer low byte at address {8'h00, Z}.
- R5: The next cycle reads the pointer high byte at {8'h00, (Z+1) mod 256}, so Z=FF wraps to 0000.
- R6: If pointer low + Y exceeds 255, the next cycle is a throwaway read at {pointer high, (low+Y) mod 256}.
- R7: The final read is at the 16-bit sum pointer + Y. It directly follows the high-byte read when there is no carry, and it follows the throwaway read when there is one. For example, pointer 1080 with Y=F1 reads 1071 and then 1171.
- R8: `done_o` is 1 for exactly one cycle, the cycle after the final read. In that same cycle `data_o` holds the byte returned by the final read.
- R9: `pc_inc_o` is 1 only in the two fetch cycles, and only together with `rd_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin a sequence (sampled while idle) |
| y_i | input | 8 | Index register value, held stable during a sequence |
| pc_i | input | 16 | Current program counter |
| rdata_i | input | 8 | Read data for the address on `addr_o`, same cycle |
| addr_o | output | 16 | Bus address |
| rd_o | output | 1 | Read strobe |
| pc_inc_o | output | 1 | Program counter advance request |
| data_o | output | 8 | Operand byte from the final read |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Counting from the first cycle after start is sampled, the address is due at cycle 0 for the opcode, 1 for the operand, 2 for the pointer low byte and 3 for the pointer high byte. The throwaway read is due at cycle 4 when the index carries. The final read is due at cycle 4 without a carry and at cycle 5 with one. `done_o` and `data_o` are due one cycle after the final read. The bench drives inputs on falling edges and compares each of these outputs on the falling edge of its own cycle. At each step it also confirms that `done_o` has not yet appeared. The bench sweeps all 256 Y values against seventeen pointer low bytes, which covers both carry and no-carry paths. It also sweeps all 256 zero-page locations, which includes the FF wrap.

// File: rtl/ind_idx_pkg.sv
package ind_idx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_OPC  = 3'd1,
    ST_OPR  = 3'd2,
    ST_PLO  = 3'd3,
    ST_PHI  = 3'd4,
    ST_FIX  = 3'd5,
    ST_DAT  = 3'd6
  } seq_state_e;
endpackage

// File: rtl/ind_idx_fsm.sv
module ind_idx_fsm
  import ind_idx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       carry_i,
  output seq_state_e state_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start_i) state_d = ST_OPC;
      ST_OPC:  state_d = ST_OPR;
      ST_OPR:  state_d = ST_PLO;
      ST_PLO:  state_d = ST_PHI;
      ST_PHI:  state_d = carry_i ? ST_FIX : ST_DAT;
      ST_FIX:  state_d = ST_DAT;
      ST_DAT:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  // Leaving idle always lands on the opcode fetch
  AST_START_TO_OPC: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_IDLE && state_q != ST_IDLE) |-> state_q == ST_OPC); // R2
  // The throwaway cycle is always followed by the final read
  AST_FIX_TO_DAT: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_FIX |=> state_q == ST_DAT); // R7
endmodule

// File: rtl/ind_idx_path.sv
module ind_idx_path
  import ind_idx_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  seq_state_e    state_i,
  input  logic [DW-1:0] y_i,
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] addr_o,
  output logic          carry_o,
  output logic [DW-1:0] data_o,
  output logic          done_o
);
  logic [DW-1:0] zp_q, lo_q, hi_q, data_q;
  logic          done_q;
  logic [DW:0]   sum;

  logic          zp_en, lo_en, hi_en, data_en;
  logic [DW-1:0] zp_d, lo_d, hi_d;

  assign sum     = {1'b0, lo_q} + {1'b0, y_i};
  assign carry_o = sum[DW];

  // Clock enables and next values
  always_comb begin
    zp_en   = 1'b0;
    lo_en   = 1'b0;
    hi_en   = 1'b0;
    data_en = 1'b0;
    zp_d    = rdata_i;
    lo_d    = rdata_i;
    hi_d    = rdata_i;
    case (state_i)
      ST_OPR: zp_en = 1'b1;
      ST_PLO: begin
        lo_en = 1'b1;
        zp_en = 1'b1;
        zp_d  = zp_q + 1'b1;
      end
      ST_PHI: begin
        hi_en = 1'b1;
        lo_en = 1'b1;
        lo_d  = sum[DW-1:0];
      end
      ST_FIX: begin
        hi_en = 1'b1;
        hi_d  = hi_q + 1'b1;
      end
      ST_DAT: data_en = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zp_q   <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      data_q <= '0;
      done_q <= 1'b0;
    end else begin
      if (zp_en)   zp_q   <= zp_d;
      if (lo_en)   lo_q   <= lo_d;
      if (hi_en)   hi_q   <= hi_d;
      if (data_en) data_q <= rdata_i;
      done_q <= data_en;
    end
  end

  always_comb begin
    case (state_i)
      ST_OPC, ST_OPR: addr_o = pc_i;
      ST_PLO, ST_PHI: addr_o = {{DW{1'b0}}, zp_q};
      ST_FIX, ST_DAT: addr_o = {hi_q, lo_q};
      default:        addr_o = '0;
    endcase
  end

  assign data_o = data_q;
  assign done_o = done_q;

  AST_HI_AFTER_LO: assert property (@(posedge clk) disable iff (!rst_n)
    state_i == ST_PHI |-> addr_o[DW-1:0] == $past(addr_o[DW-1:0]) + 1'b1); // R5
  AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == ST_DAT && $past(state_i) == ST_FIX) |->
      addr_o == $past(addr_o) + (AW'(1) << DW)); // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8
endmodule

// File: rtl/ind_idx_seq.sv
module ind_idx_seq
  import ind_idx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [7:0]  y_i,
  input  logic [15:0] pc_i,
  input  logic [7:0]  rdata_i,
  output logic [15:0] addr_o,
  output logic        rd_o,
  output logic        pc_inc_o,
  output logic [7:0]  data_o,
  output logic        done_o
);
  localparam int DW = 8;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  seq_state_e state;
  logic       carry;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ind_idx_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start_i (start_i),
    .carry_i (carry),
    .state_o (state)
  );

  ind_idx_path #(.DW(DW)) u_path (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .state_i (state),
    .y_i     (y_i),
    .pc_i    (pc_i),
    .rdata_i (rdata_i),
    .addr_o  (addr_o),
    .carry_o (carry),
    .data_o  (data_o),
    .done_o  (done_o)
  );

  assign rd_o     = (state != ST_IDLE);
  assign pc_inc_o = (state == ST_OPC) || (state == ST_OPR);

  AST_PCINC_WITH_READ: assert property (@(posedge clk) disable iff (!rst_int_n)
    pc_inc_o |-> rd_o); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |-> !rd_o); // R8
endmodule

// File: tb/tb_ind_idx_seq.sv
module tb_ind_idx_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [7:0]  y_i;
  logic [15:0] pc_i;
  logic [7:0]  rdata_i;
  logic [15:0] addr_o;
  logic        rd_o, pc_inc_o, done_o;
  logic [7:0]  data_o;

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0]  zmem [256];
  logic [15:0] opc_addr;
  logic [7:0]  opnd;

  always #4 clk = ~clk;

  ind_idx_seq dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .y_i(y_i), .pc_i(pc_i),
    .rdata_i(rdata_i), .addr_o(addr_o), .rd_o(rd_o), .pc_inc_o(pc_inc_o),
    .data_o(data_o), .done_o(done_o)
  );

  function automatic logic [7:0] model(input logic [15:0] a);
    if (a == opc_addr)             return 8'hB1;
    if (a == opc_addr + 16'd1)     return opnd;
    if (a[15:8] == 8'h00)          return zmem[a[7:0]];
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  always_comb rdata_i = model(addr_o);

  always @(posedge clk) if (pc_inc_o) pc_i <= pc_i + 16'd1;

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [7:0] zp, input logic [7:0] y);
    logic [15:0] p0, ptr, fin;
    logic [8:0]  s;
    @(negedge clk);
    p0 = pc_i; opc_addr = p0; opnd = zp; y_i = y; start_i = 1'b1;
    ptr = {zmem[zp + 8'd1], zmem[zp]};
    s = {1'b0, ptr[7:0]} + {1'b0, y};
    fin = ptr + {8'h00, y};
    @(negedge clk); start_i = 1'b0;
    chk(addr_o == p0 && rd_o && pc_inc_o, "R2 opcode fetch", addr_o, p0);
    @(negedge clk);
    chk(addr_o == p0 + 16'd1 && pc_inc_o, "R3 operand fetch", addr_o, p0 + 16'd1);
    @(negedge clk);
    chk(addr_o == {8'h00, zp} && !pc_inc_o, "R4 pointer low", addr_o, {8'h00, zp});
    @(negedge clk);
    chk(addr_o == {8'h00, zp + 8'd1} && !pc_inc_o, "R5 pointer high", addr_o, {8'h00, zp + 8'd1});
    chk(!done_o, "R8 early done", {15'd0, done_o}, 16'd0);
    if (s[8]) begin
      @(negedge clk);
      chk(addr_o == {ptr[15:8], s[7:0]} && rd_o, "R6 throwaway read", addr_o, {ptr[15:8], s[7:0]});
      chk(!done_o, "R8 early done", {15'd0, done_o}, 16'd0);
    end
    @(negedge clk);
    chk(addr_o == fin && rd_o && !pc_inc_o, "R7 final read", addr_o, fin);
    chk(!done_o, "R8 early done", {15'd0, done_o}, 16'd0);
    @(negedge clk);
    chk(done_o && data_o == model(fin), "R8 done and data", {7'd0, done_o, data_o}, {8'd1, model(fin)});
    chk(!rd_o && !pc_inc_o, "R9 idle after done", {14'd0, rd_o, pc_inc_o}, 16'd0);
    @(negedge clk);
    chk(!done_o, "R8 single pulse", {15'd0, done_o}, 16'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; y_i = 8'h00; pc_i = 16'h8000;
    opc_addr = 16'h8000; opnd = 8'h00;
    for (int i = 0; i < 256; i++) zmem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset/idle state
    chk(!rd_o && !pc_inc_o && !done_o, "R1 idle outputs", {13'd0, rd_o, pc_inc_o, done_o}, 16'd0);
    repeat (3) @(negedge clk);
    chk(!rd_o && !done_o, "R1 idle holds", {14'd0, rd_o, done_o}, 16'd0);

    // Worked case: pointer 1080, Y=F1 -> 1071 then 1171
    zmem[8'h42] = 8'h80; zmem[8'h43] = 8'h10;
    run(8'h42, 8'hF1);

    // Y sweep against pointer low bytes (carry and no-carry)
    for (int li = 0; li < 17; li++) begin
      zmem[8'h42] = (li == 16) ? 8'hFF : 8'(li * 16);
      zmem[8'h43] = 8'h10 + 8'(li);
      for (int yy = 0; yy < 256; yy++) run(8'h42, 8'(yy));
    end

    // Zero-page location sweep, including FF wrap (R5)
    for (int i = 0; i < 256; i++) zmem[i] = 8'(i * 7 + 3);
    for (int z = 0; z < 256; z++) run(8'(z), 8'(z * 13));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule